// File: doc/BRIEF.md
# Multiplexed Analogue Frame Capture

This block sits behind a 40 MHz ADC that digitises the serial analogue output of a 128-channel strip readout chip. A frame on that line is 144 time slots of one sample each. The first 16 slots are header slots and the next 128 are channel slots, sent in increasing channel order. The chip raises a data-valid strobe for the length of a frame. The block finds the start of each frame from the rising edge of that strobe. It then skips a programmable number of cycles to cover the ADC pipeline latency and tags every captured sample as header or channel, together with its index.

Each captured slot leaves as one beat on a registered output stream. A beat carries the sample, converted from the ADC's sign-magnitude code to two's complement, a header flag, an 8-bit index and a last marker on channel 127. If the strobe falls before the whole frame is in, the block closes the partial frame with a single abort beat and pulses an error line. A 16-bit counter records how many frames completed. Storage, host transfer and the ADC itself belong to other blocks.

Top module: `fc_frame_capture`

## Requirements
- R1: While reset is held and right after it is released, beat_valid, beat_is_hdr, beat_last, beat_abort and trunc_err are 0, beat_index and beat_sample are 0, and frames_done is 0. Every field reads 0 in any cycle without a beat.
- R2: A frame starts in a cycle where adc_dv is 1 and was 0 in the cycle before. With K the value of cfg_align in that cycle (0 to 7), the sample presented K cycles later is header slot 0. Changing cfg_align after the start cycle has no effect on that frame.
- R3: The sample taken in cycle n appears as a beat in cycle n+1. The 16 header samples come out on consecutive cycles with beat_is_hdr=1 and beat_index 0 to 15.
- R4: The 128 channel samples follow directly with beat_is_hdr=0 and beat_index 0 to 127. beat_last is 1 only on channel 127 and on abort beats.
- R5: adc_code bit 9 is the sign (1 means negative) and bits 8:0 are the magnitude. beat_sample is the same value in 10-bit two's complement: a negative zero gives 0, and -512 never occurs.
- R6: If adc_dv is 0 in any cycle after the start cycle and before the 144th slot is taken, the frame ends. The beat of the following cycle has beat_valid=1, beat_last=1, beat_abort=1, beat_is_hdr=0, index 0 and sample 0, and trunc_err is 1 for that one cycle.
- R7: frames_done goes up by one in the same cycle as the last beat of each complete frame. Aborted frames leave it unchanged.
- R8: After a complete frame, samples produce no beats while adc_dv stays 1. A new frame needs adc_dv to be 0 for at least one cycle and then rise again, and a single low cycle between frames is enough.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_dv | input | 1 | Frame-present strobe from the readout chip |
| adc_code | input | 10 | ADC sample, sign-magnitude |
| cfg_align | input | 3 | Cycles from the strobe's rising edge to header slot 0 |
| beat_valid | output | 1 | Beat present |
| beat_sample | output | 10 | Sample in two's complement |
| beat_is_hdr | output | 1 | 1 for a header slot, 0 for a channel slot |
| beat_index | output | 8 | Header index 0-15 or channel index 0-127 |
| beat_last | output | 1 | Final beat of a frame (channel 127 or abort) |
| beat_abort | output | 1 | Beat closes a truncated frame |
| trunc_err | output | 1 | One-cycle pulse on a truncated frame |
| frames_done | output | 16 | Count of complete frames |

## Verification
The assertions check on every cycle that beats in a frame follow each other without gaps, and that a last beat that is not an abort is always channel 127. They also check that an abort beat carries last, that -512 never appears on the output, and that the frame count changes only on a completed last beat. Only the bench scenarios can show the other behaviour: the exact cycle header slot 0 lands for each alignment value, that a mid-frame change of cfg_align is ignored, the sample values after sign conversion, truncation during alignment, header or channel phase, and that trailing strobe cycles after a full frame produce nothing.

// File: rtl/fc_pkg.sv
package fc_pkg;

  // Width of the ADC code: one sign bit plus magnitude bits.
  localparam int ADC_W = 10;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ALIGN = 2'd1,
    ST_CAPT  = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_e;

  // Sign-magnitude ADC code to two's complement of the same width.
  function automatic logic [ADC_W-1:0] sm_to_tc(input logic [ADC_W-1:0] code);
    logic [ADC_W-1:0] mag;
    mag = {1'b0, code[ADC_W-2:0]};
    if (code[ADC_W-1]) return (~mag) + 1'b1;
    return mag;
  endfunction

  // Position of a slot inside its own section (header or channel).
  function automatic int slot_index(input int slot, input int hdr_slots);
    return (slot < hdr_slots) ? slot : slot - hdr_slots;
  endfunction

  function automatic logic slot_is_hdr(input int slot, input int hdr_slots);
    return slot < hdr_slots;
  endfunction

endpackage

// File: rtl/fc_rise_det.sv
module fc_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic dv,
  output logic rise
);
  logic dv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dv_q <= 1'b0;
    else        dv_q <= dv;
  end

  assign rise = dv && !dv_q;
endmodule

// File: rtl/fc_sequencer.sv
module fc_sequencer
  import fc_pkg::*;
#(
  parameter int HDR_SLOTS  = 16,
  parameter int CHAN_SLOTS = 128,
  parameter int OFF_W      = 3,
  localparam int TOTAL     = HDR_SLOTS + CHAN_SLOTS,
  localparam int SLOT_W    = $clog2(TOTAL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dv,
  input  logic              rise,
  input  logic [OFF_W-1:0]  cfg_off,
  output logic              take,
  output logic              abort,
  output logic [SLOT_W-1:0] slot
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(TOTAL - 1);

  seq_state_e        state_q;
  logic [OFF_W-1:0]  rem_q;
  logic [SLOT_W-1:0] slot_q;

  always_comb begin
    take  = 1'b0;
    abort = 1'b0;
    slot  = slot_q;
    case (state_q)
      ST_IDLE: begin
        if (rise && cfg_off == '0) begin
          take = 1'b1;
          slot = '0;
        end
      end
      ST_ALIGN: begin
        if (!dv) abort = 1'b1;
        else if (rem_q == OFF_W'(1)) begin
          take = 1'b1;
          slot = '0;
        end
      end
      ST_CAPT: begin
        if (!dv) abort = 1'b1;
        else     take  = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      slot_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (rise) begin
            if (cfg_off == '0) begin
              state_q <= ST_CAPT;
              slot_q  <= SLOT_W'(1);
            end else begin
              state_q <= ST_ALIGN;
              rem_q   <= cfg_off;
            end
          end
        end
        ST_ALIGN: begin
          if (!dv) state_q <= ST_IDLE;
          else if (rem_q == OFF_W'(1)) begin
            state_q <= ST_CAPT;
            slot_q  <= SLOT_W'(1);
          end else begin
            rem_q <= rem_q - 1'b1;
          end
        end
        ST_CAPT: begin
          if (!dv)                      state_q <= ST_IDLE;
          else if (slot_q == LAST_SLOT) state_q <= ST_DONE;
          else                          slot_q  <= slot_q + 1'b1;
        end
        default: begin
          if (!dv) state_q <= ST_IDLE;
        end
      endcase
    end
  end

  // R6: a truncation always returns the sequencer to idle
  a_r6_abort_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> state_q == ST_IDLE);

  // R2: alignment phase only entered from a strobe rising edge
  a_r2_align_from_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_ALIGN) |-> $past(rise));

  // R8: a completed frame is left only through a low strobe
  a_r8_done_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE && dv) |=> state_q == ST_DONE);
endmodule

// File: rtl/fc_beat_fmt.sv
module fc_beat_fmt
  import fc_pkg::*;
#(
  parameter int HDR_SLOTS  = 16,
  parameter int CHAN_SLOTS = 128,
  parameter int IDX_W      = 8,
  localparam int TOTAL     = HDR_SLOTS + CHAN_SLOTS,
  localparam int SLOT_W    = $clog2(TOTAL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              abort,
  input  logic [SLOT_W-1:0] slot,
  input  logic [ADC_W-1:0]  code,
  output logic              valid_o,
  output logic [ADC_W-1:0]  sample_o,
  output logic              is_hdr_o,
  output logic [IDX_W-1:0]  index_o,
  output logic              last_o,
  output logic              abort_o,
  output logic              err_o,
  output logic              frame_end
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(TOTAL - 1);

  assign frame_end = take && (slot == LAST_SLOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o  <= 1'b0;
      sample_o <= '0;
      is_hdr_o <= 1'b0;
      index_o  <= '0;
      last_o   <= 1'b0;
      abort_o  <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      valid_o  <= take || abort;
      sample_o <= take ? sm_to_tc(code) : '0;
      is_hdr_o <= take && slot_is_hdr(int'(slot), HDR_SLOTS);
      index_o  <= take ? IDX_W'(slot_index(int'(slot), HDR_SLOTS)) : '0;
      last_o   <= frame_end || abort;
      abort_o  <= abort;
      err_o    <= abort;
    end
  end

  // R4: a normal last beat is the final channel
  a_r4_last_is_final_chan: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !abort_o) |-> (valid_o && !is_hdr_o && index_o == IDX_W'(CHAN_SLOTS - 1)));

  // R6: abort beats are valid and close the frame
  a_r6_abort_beat: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> (valid_o && last_o && err_o && sample_o == '0));

  // R5: sign-magnitude input can never yield the most negative code
  a_r5_no_min_code: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> sample_o != {1'b1, {(ADC_W-1){1'b0}}});

  // R3: every beat but header slot 0 follows a data beat with no gap
  a_r3_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !abort_o && !(is_hdr_o && index_o == '0)) |-> ($past(valid_o) && !$past(abort_o)));
endmodule

// File: rtl/fc_frame_ctr.sv
module fc_frame_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= count + 1'b1;
  end
endmodule

// File: rtl/fc_frame_capture.sv
module fc_frame_capture
  import fc_pkg::*;
#(
  parameter int HDR_SLOTS  = 16,
  parameter int CHAN_SLOTS = 128,
  parameter int OFF_W      = 3,
  parameter int IDX_W      = 8,
  parameter int CNT_W      = 16,
  localparam int SLOT_W    = $clog2(HDR_SLOTS + CHAN_SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adc_dv,
  input  logic [ADC_W-1:0] adc_code,
  input  logic [OFF_W-1:0] cfg_align,
  output logic             beat_valid,
  output logic [ADC_W-1:0] beat_sample,
  output logic             beat_is_hdr,
  output logic [IDX_W-1:0] beat_index,
  output logic             beat_last,
  output logic             beat_abort,
  output logic             trunc_err,
  output logic [CNT_W-1:0] frames_done
);
  logic              dv_rise;
  logic              slot_take;
  logic              slot_abort;
  logic [SLOT_W-1:0] slot_num;
  logic              frame_end;

  fc_rise_det u_rise (
    .clk  (clk),
    .rst_n(rst_n),
    .dv   (adc_dv),
    .rise (dv_rise)
  );

  fc_sequencer #(
    .HDR_SLOTS (HDR_SLOTS),
    .CHAN_SLOTS(CHAN_SLOTS),
    .OFF_W     (OFF_W)
  ) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .dv     (adc_dv),
    .rise   (dv_rise),
    .cfg_off(cfg_align),
    .take   (slot_take),
    .abort  (slot_abort),
    .slot   (slot_num)
  );

  fc_beat_fmt #(
    .HDR_SLOTS (HDR_SLOTS),
    .CHAN_SLOTS(CHAN_SLOTS),
    .IDX_W     (IDX_W)
  ) u_fmt (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (slot_take),
    .abort    (slot_abort),
    .slot     (slot_num),
    .code     (adc_code),
    .valid_o  (beat_valid),
    .sample_o (beat_sample),
    .is_hdr_o (beat_is_hdr),
    .index_o  (beat_index),
    .last_o   (beat_last),
    .abort_o  (beat_abort),
    .err_o    (trunc_err),
    .frame_end(frame_end)
  );

  fc_frame_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk  (clk),
    .rst_n(rst_n),
    .inc  (frame_end),
    .count(frames_done)
  );

  // R7: counter steps exactly with a completed last beat
  a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_last && !beat_abort) |-> frames_done == $past(frames_done) + 1'b1);

  a_r7_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(beat_valid && beat_last && !beat_abort) |-> $stable(frames_done));
endmodule

// File: tb/fc_frame_capture_tb.sv
module fc_frame_capture_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       adc_dv;
  logic [9:0] adc_code;
  logic [2:0] cfg_align;
  logic       beat_valid, beat_is_hdr, beat_last, beat_abort, trunc_err;
  logic [9:0] beat_sample;
  logic [7:0] beat_index;
  logic [15:0] frames_done;

  always #4 clk = ~clk;

  fc_frame_capture u_dut (
    .clk(clk), .rst_n(rst_n), .adc_dv(adc_dv), .adc_code(adc_code),
    .cfg_align(cfg_align), .beat_valid(beat_valid), .beat_sample(beat_sample),
    .beat_is_hdr(beat_is_hdr), .beat_index(beat_index), .beat_last(beat_last),
    .beat_abort(beat_abort), .trunc_err(trunc_err), .frames_done(frames_done)
  );

  // Frame scenarios: {alignment, slots before strobe drop (144 = full), trailing high cycles, seed}
  localparam int NFR = 9;
  localparam int FRAMES [NFR][4] = '{
    '{0, 144, 0, 0}, '{3, 144, 4, 2}, '{7, 144, 1, 3}, '{2, 10, 0, 4},
    '{1, 100, 0, 5}, '{5, 0, 0, 6},   '{0, 143, 0, 7}, '{4, 144, 2, 8},
    '{6, 16, 0, 9}
  };
  // Sign table: {adc code, expected two's complement value}, used by seed 0
  localparam int NTAB = 6;
  localparam int SIGN_TAB [NTAB][2] = '{
    '{0, 0}, '{512, 0}, '{511, 511}, '{1023, -511}, '{513, -1}, '{1, 1}
  };

  int checks = 0;
  int errors = 0;
  int exp_fc = 0;
  bit p_armed, p_valid, p_hdr, p_last, p_abort;
  int p_idx, p_sample;
  string p_req;

  function automatic int pat(input int seed, input int slot);
    if (seed == 0 && slot < NTAB) return SIGN_TAB[slot][0];
    return (slot * 149 + seed * 61 + 7) % 1024;
  endfunction

  function automatic int ref_val(input int seed, input int slot);
    int c;
    int m;
    if (seed == 0 && slot < NTAB) return SIGN_TAB[slot][1];
    c = pat(seed, slot);
    m = c % 512;
    return (c >= 512) ? -m : m;
  endfunction

  task automatic compare();
    if (!p_armed) return;
    if (p_valid && p_last && !p_abort) exp_fc++;
    checks++;
    if (beat_valid !== p_valid || beat_is_hdr !== p_hdr || beat_last !== p_last ||
        beat_abort !== p_abort || trunc_err !== p_abort ||
        int'(beat_index) != p_idx || int'($signed(beat_sample)) != p_sample) begin
      errors++;
      $display("FAIL %s: got v=%0b h=%0b i=%0d s=%0d l=%0b a=%0b e=%0b, expected v=%0b h=%0b i=%0d s=%0d l=%0b a=%0b e=%0b",
               p_req, beat_valid, beat_is_hdr, beat_index, $signed(beat_sample), beat_last,
               beat_abort, trunc_err, p_valid, p_hdr, p_idx, p_sample, p_last, p_abort, p_abort);
    end
    checks++;
    if (int'(frames_done) != exp_fc) begin
      errors++;
      $display("FAIL R7 frame count: got %0d expected %0d", frames_done, exp_fc);
    end
  endtask

  task automatic step(input logic dv, input int code, input int off,
                      input bit ev, input bit eh, input int ei, input int es,
                      input bit el, input bit ea, input string req);
    @(negedge clk);
    compare();
    adc_dv    = dv;
    adc_code  = 10'(code);
    cfg_align = 3'(off);
    p_armed = 1'b1; p_valid = ev; p_hdr = eh; p_idx = ei; p_sample = es;
    p_last = el; p_abort = ea; p_req = req;
  endtask

  task automatic run_frame(input int off, input int n, input int extra, input int seed);
    int other;
    other = 7 - off;  // R2: applied after the start cycle, must be ignored
    for (int i = 0; i < off + n; i++) begin
      int o;
      o = (i == 0) ? off : other;
      if (i < off) begin
        step(1'b1, pat(seed, 200 + i), o, 0, 0, 0, 0, 0, 0, "R2 alignment wait");
      end else begin
        int s;
        s = i - off;
        if (s < 16)
          step(1'b1, pat(seed, s), o, 1, 1, s, ref_val(seed, s), 0, 0, "R3/R5 header beat");
        else
          step(1'b1, pat(seed, s), o, 1, 0, s - 16, ref_val(seed, s), s == 143, 0, "R4/R5 channel beat");
      end
    end
    if (n < 144) begin
      step(1'b0, 0, other, 1, 0, 0, 0, 1, 1, "R6 truncated frame");
    end else begin
      for (int j = 0; j < extra; j++)
        step(1'b1, pat(seed, 300 + j), other, 0, 0, 0, 0, 0, 0, "R8 trailing strobe ignored");
      step(1'b0, 0, other, 0, 0, 0, 0, 0, 0, "R8 gap between frames");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; adc_dv = 1'b0; adc_code = '0; cfg_align = '0;
    p_armed = 1'b1; p_valid = 0; p_hdr = 0; p_last = 0; p_abort = 0;
    p_idx = 0; p_sample = 0; p_req = "R1 reset state";
    repeat (3) @(negedge clk);
    compare();  // R1 while reset is held
    rst_n = 1'b1;
    step(1'b0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 after release");

    // Table of scenarios walked by one loop
    for (int f = 0; f < NFR; f++)
      run_frame(FRAMES[f][0], FRAMES[f][1], FRAMES[f][2], FRAMES[f][3]);

    // Directed: reset in mid-frame clears beats and the count (R1)
    step(1'b1, 5, 0, 1, 1, 0, 5, 0, 0, "R3 header slot 0");
    step(1'b1, 6, 0, 1, 1, 1, 6, 0, 0, "R3 header slot 1");
    @(negedge clk);
    compare();
    rst_n = 1'b0; adc_dv = 1'b0; p_armed = 1'b0;
    @(negedge clk);
    exp_fc = 0;
    p_armed = 1'b1; p_valid = 0; p_hdr = 0; p_last = 0; p_abort = 0;
    p_idx = 0; p_sample = 0; p_req = "R1 reset mid-frame";
    compare();
    rst_n = 1'b1;
    step(1'b0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 after second release");

    // Recovery with a full frame at the largest alignment
    run_frame(7, 144, 0, 11);
    step(1'b0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 idle");
    @(negedge clk);
    compare();
    p_armed = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule